// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a small bank of control registers that sits on a workstation I/O controller. A host writes and reads the bank through a bus. Each register has its own select line. The bank holds:

- five byte registers: configuration, diagnostic, modem control, auxiliary-1 and auxiliary-2;
- a 16-bit indicator (LED) register;
- a 32-bit system control register.

Several bits have side effects rather than plain storage. Writing one bit of auxiliary-1 sends a one-cycle terminal-count strobe to a floppy controller. Auxiliary-2 holds a power-off trigger and a sticky power-fail flag, which a write-one-to-clear bit clears. The system control register raises a reset request and records that it did so.

A power-fail input drives the sticky flag through a two-state machine. The machine has two states:

- `PF_IDLE`: no fault latched.
- `PF_LATCHED`: a power failure was seen while the power interrupt was enabled.

It has three transitions:

- **set**: in `PF_IDLE`, the input changes to asserted while configuration bit 3 is 1. The machine moves to `PF_LATCHED`.
- **drop**: in `PF_LATCHED`, the input changes and the enabled-assertion condition no longer holds. The machine moves to `PF_IDLE`.
- **clear**: in `PF_LATCHED`, auxiliary-2 is written with bit 1 set in a cycle with no input change. The machine moves to `PF_IDLE`.

The level interrupt is the AND of `PF_LATCHED` and configuration bit 3. The power-fail input is compared against its value in the previous cycle, and an input change always takes priority over the clear.

Top module: `aux_ctrl_bank`

## Requirements
- R1: `irq` is 1 exactly when the power-fail flag (auxiliary-2 bit 5) is set and configuration bit 3 is set, one cycle after the write that changes either. Clearing configuration bit 3 drops `irq` but leaves bit 5 readable.
- R2: On a change of `pwr_fail_in`, the flag is set if the new level is 1 and configuration bit 3 is currently 1. Otherwise the flag is cleared. Enabling configuration bit 3 later does not set the flag on its own.
- R3: A write to auxiliary-1 with bit 1 set pulses `tc_pulse`. Auxiliary-1 stores the written byte with bit 1 forced to 0.
- R4: An auxiliary-2 write keeps only bits 0 and 1 of the data, and its read value is {bit5 = flag, bit0 = stored power-off}. Bit 1 written as 1 clears the flag; otherwise the flag is kept.
- R5: An auxiliary-2 write that leaves bit 0 set pulses `shutdown_req`.
- R6: A system-control write at offset 0 with bit 0 set loads 32'h0000_0002 and pulses `reset_req`. A write with bit 0 clear changes nothing.
- R7: Configuration, diagnostic and modem-control registers store and read back all 8 bits. The LED register stores the low 16 bits. All reads are zero-extended to 32 bits.
- R8: Reset clears configuration, auxiliary-1, auxiliary-2 (including the flag) and modem control. Reset keeps the diagnostic, LED and system-control registers.
- R9: For the LED and system-control registers, a `word_off` other than 0 reads zero, and a write at such an offset changes nothing and pulses nothing.
- R10: `tc_pulse`, `shutdown_req` and `reset_req` are 0 after reset. Each is high for exactly the one cycle after its write.
- R11: `reg_sel` bit mapping:

  | Bit | Register |
  |-----|----------|
  | 0 | configuration |
  | 1 | diagnostic |
  | 2 | modem control |
  | 3 | auxiliary-1 |
  | 4 | auxiliary-2 |
  | 5 | LED |
  | 6 | system control |

  With no select bit set, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 7 | One select line per register |
| word_off | input | 2 | Word offset within the LED and system-control windows |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register (combinational) |
| pwr_fail_in | input | 1 | Power-fail level from the supply monitor |
| irq | output | 1 | Level interrupt for power failure |
| tc_pulse | output | 1 | One-cycle terminal-count strobe |
| shutdown_req | output | 1 | One-cycle power-off request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach from the ports is a latched flag whose interrupt is masked. Reaching it takes a fixed order of steps:

1. Enable configuration bit 3.
2. Change the power-fail input.
3. Clear the enable.

The stimulus follows that order, confirms that bit 5 still reads back while `irq` is low, and then re-enables the interrupt to show the latched flag return. It also proves that only an input change sets the flag. It raises the input while the enable is off and then enables it, and expects no flag.

// File: rtl/aux_bank_pkg.sv
package aux_bank_pkg;
    localparam int NSEL     = 7;
    localparam int SEL_CFG  = 0;
    localparam int SEL_DIAG = 1;
    localparam int SEL_MDM  = 2;
    localparam int SEL_AUX1 = 3;
    localparam int SEL_AUX2 = 4;
    localparam int SEL_LED  = 5;
    localparam int SEL_SYSC = 6;

    localparam int NPULSE    = 3;
    localparam int PULSE_TC  = 0;
    localparam int PULSE_OFF = 1;
    localparam int PULSE_RST = 2;

    typedef enum logic {
        PF_IDLE    = 1'b0,
        PF_LATCHED = 1'b1
    } pf_state_e;
endpackage

// File: rtl/aux_pf_fsm.sv
module aux_pf_fsm
    import aux_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pf_in,
    input  logic pf_en,
    input  logic clr_req,
    output logic pf_flag,
    output logic pf_irq
);
    pf_state_e state_q;
    pf_state_e state_nx;
    logic      pf_prev_q;
    logic      pf_change;

    assign pf_change = pf_prev_q ^ pf_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_prev_q <= 1'b0;
        end else begin
            pf_prev_q <= pf_in;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PF_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // next state: an input change always wins over a clear request
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            PF_IDLE: begin
                if (pf_change && pf_in && pf_en) begin
                    state_nx = PF_LATCHED;
                end
            end
            PF_LATCHED: begin
                if (pf_change) begin
                    if (!(pf_in && pf_en)) begin
                        state_nx = PF_IDLE;
                    end
                end else if (clr_req) begin
                    state_nx = PF_IDLE;
                end
            end
            default: state_nx = PF_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pf_flag = (state_q == PF_LATCHED);
        pf_irq  = pf_flag && pf_en;
    end
endmodule

// File: rtl/aux_pulse_gen.sv
module aux_pulse_gen #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig,
    output logic [N-1:0] pulse
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_pulse
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= 1'b0;
                end else begin
                    q <= trig[i];
                end
            end
            assign pulse[i] = q;
        end
    endgenerate
endmodule

// File: rtl/aux_rd_mux.sv
module aux_rd_mux #(
    parameter int N = 7,
    parameter int W = 32
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] words_flat,
    output logic [W-1:0]   rdata
);
    logic [W-1:0] gated [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_gate
            assign gated[i] = sel[i] ? words_flat[i*W +: W] : '0;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            rdata = rdata | gated[i];
        end
    end
endmodule

// File: rtl/aux_ctrl_bank.sv
module aux_ctrl_bank
    import aux_bank_pkg::*;
#(
    parameter int          BYTE_W    = 8,
    parameter int          LED_W     = 16,
    parameter int          WORD_W    = 32,
    parameter int          OFF_W     = 2,
    parameter int          PIEN_BIT  = 3,
    parameter int          TC_BIT    = 1,
    parameter int          POFF_BIT  = 0,
    parameter int          CLR_BIT   = 1,
    parameter int          FLAG_BIT  = 5,
    parameter int          RST_BIT   = 0,
    parameter logic [31:0] RSTAT_VAL = 32'h0000_0002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSEL-1:0]   reg_sel,
    input  logic [OFF_W-1:0]  word_off,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              pwr_fail_in,
    output logic              irq,
    output logic              tc_pulse,
    output logic              shutdown_req,
    output logic              reset_req
);
    localparam logic [BYTE_W-1:0] TC_MASK = BYTE_W'(1) << TC_BIT;

    logic [NSEL-1:0]      wr_hit;
    logic                 off_zero;
    logic [BYTE_W-1:0]    cfg_q, diag_q, mdm_q, aux1_q;
    logic                 aux2_off_q;
    logic [LED_W-1:0]     led_q;
    logic [WORD_W-1:0]    sysc_q;
    logic                 pf_flag;
    logic [NPULSE-1:0]    trig;
    logic [NPULSE-1:0]    pulse;
    logic [NSEL*WORD_W-1:0] words_flat;
    logic [WORD_W-1:0]    aux2_rd;
    logic                 unused_wr_hi;

    assign wr_hit       = reg_sel & {NSEL{wr_en}};
    assign off_zero     = (word_off == '0);
    assign unused_wr_hi = ^wr_data[WORD_W-1:LED_W];

    // registers cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            mdm_q      <= '0;
            aux1_q     <= '0;
            aux2_off_q <= 1'b0;
        end else begin
            if (wr_hit[SEL_CFG]) begin
                cfg_q <= wr_data[BYTE_W-1:0];
            end
            if (wr_hit[SEL_MDM]) begin
                mdm_q <= wr_data[BYTE_W-1:0];
            end
            if (wr_hit[SEL_AUX1]) begin
                aux1_q <= wr_data[BYTE_W-1:0] & ~TC_MASK;
            end
            if (wr_hit[SEL_AUX2]) begin
                aux2_off_q <= wr_data[POFF_BIT];
            end
        end
    end

    // registers preserved across reset
    always_ff @(posedge clk) begin
        if (wr_hit[SEL_DIAG]) begin
            diag_q <= wr_data[BYTE_W-1:0];
        end
        if (wr_hit[SEL_LED] && off_zero) begin
            led_q <= wr_data[LED_W-1:0];
        end
        if (wr_hit[SEL_SYSC] && off_zero && wr_data[RST_BIT]) begin
            sysc_q <= RSTAT_VAL[WORD_W-1:0];
        end
    end

    aux_pf_fsm pf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pf_in   (pwr_fail_in),
        .pf_en   (cfg_q[PIEN_BIT]),
        .clr_req (wr_hit[SEL_AUX2] && wr_data[CLR_BIT]),
        .pf_flag (pf_flag),
        .pf_irq  (irq)
    );

    always_comb begin
        trig            = '0;
        trig[PULSE_TC]  = wr_hit[SEL_AUX1] && wr_data[TC_BIT];
        trig[PULSE_OFF] = wr_hit[SEL_AUX2] && wr_data[POFF_BIT];
        trig[PULSE_RST] = wr_hit[SEL_SYSC] && off_zero && wr_data[RST_BIT];
    end

    aux_pulse_gen #(.N(NPULSE)) pulse_i (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig),
        .pulse (pulse)
    );

    assign tc_pulse     = pulse[PULSE_TC];
    assign shutdown_req = pulse[PULSE_OFF];
    assign reset_req    = pulse[PULSE_RST];

    always_comb begin
        aux2_rd           = '0;
        aux2_rd[FLAG_BIT] = pf_flag;
        aux2_rd[POFF_BIT] = aux2_off_q;
        words_flat = '0;
        words_flat[SEL_CFG*WORD_W  +: WORD_W] = WORD_W'(cfg_q);
        words_flat[SEL_DIAG*WORD_W +: WORD_W] = WORD_W'(diag_q);
        words_flat[SEL_MDM*WORD_W  +: WORD_W] = WORD_W'(mdm_q);
        words_flat[SEL_AUX1*WORD_W +: WORD_W] = WORD_W'(aux1_q);
        words_flat[SEL_AUX2*WORD_W +: WORD_W] = aux2_rd;
        words_flat[SEL_LED*WORD_W  +: WORD_W] = off_zero ? WORD_W'(led_q) : '0;
        words_flat[SEL_SYSC*WORD_W +: WORD_W] = off_zero ? sysc_q : '0;
    end

    aux_rd_mux #(.N(NSEL), .W(WORD_W)) rd_i (
        .sel        (reg_sel),
        .words_flat (words_flat),
        .rdata      (rd_data)
    );
endmodule

// File: rtl/aux_ctrl_bank_chk.sv
module aux_ctrl_bank_chk
    import aux_bank_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int OFF_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSEL-1:0]   reg_sel,
    input logic [OFF_W-1:0]  word_off,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic              pwr_fail_in,
    input logic              irq,
    input logic              tc_pulse,
    input logic              shutdown_req,
    input logic              reset_req,
    input logic [WORD_W-1:0] sysc_q
);
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(wr_en) || $past(pwr_fail_in))); // R1

    AST_TC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(wr_en && reg_sel[SEL_AUX1] && wr_data[1])); // R3

    AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel[SEL_AUX2] && wr_data[1] && $stable(pwr_fail_in)) |=> !irq); // R4

    AST_SHUTDOWN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(wr_en && reg_sel[SEL_AUX2] && wr_data[0])); // R5

    AST_RESET_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(wr_en && reg_sel[SEL_SYSC] && (word_off == '0) && wr_data[0])); // R9

    AST_RESET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (sysc_q == 32'h0000_0002)); // R6
endmodule

bind aux_ctrl_bank aux_ctrl_bank_chk #(.WORD_W(WORD_W), .OFF_W(OFF_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_sel      (reg_sel),
    .word_off     (word_off),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .pwr_fail_in  (pwr_fail_in),
    .irq          (irq),
    .tc_pulse     (tc_pulse),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .sysc_q       (sysc_q)
);

// File: tb/aux_ctrl_bank_tb.sv
module aux_ctrl_bank_tb_top;
    localparam int CFG = 0, DIAG = 1, MDM = 2, AUX1 = 3, AUX2 = 4, LED = 5, SYSC = 6;

    typedef struct packed {
        logic [7:0]  req;
        logic [2:0]  idx;
        logic [1:0]  off;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    // write idx/off with wd, then read idx/off and expect exp
    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{8'd7, 3'd0, 2'd0, 32'h0000_00A5, 32'h0000_00A5}, // R7 cfg
        '{8'd7, 3'd1, 2'd0, 32'hFFFF_FF3C, 32'h0000_003C}, // R7 diag
        '{8'd7, 3'd2, 2'd0, 32'h0000_00FF, 32'h0000_00FF}, // R7 modem
        '{8'd7, 3'd5, 2'd0, 32'hDEAD_BEEF, 32'h0000_BEEF}, // R7 led
        '{8'd9, 3'd5, 2'd1, 32'h0000_1234, 32'h0000_0000}, // R9 led off1
        '{8'd6, 3'd6, 2'd0, 32'h0000_0001, 32'h0000_0002}, // R6 sysc load
        '{8'd6, 3'd6, 2'd0, 32'hFFFF_FFFE, 32'h0000_0002}, // R6 bit0 clear
        '{8'd9, 3'd6, 2'd2, 32'h0000_0001, 32'h0000_0000}, // R9 sysc off2
        '{8'd3, 3'd3, 2'd0, 32'h0000_00FF, 32'h0000_00FD}, // R3 aux1
        '{8'd4, 3'd4, 2'd0, 32'h0000_00FC, 32'h0000_0000}, // R4 aux2 mask
        '{8'd7, 3'd0, 2'd0, 32'h0000_0052, 32'h0000_0052}  // R7 cfg
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_sel = '0;
    logic [1:0]  word_off = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwr_fail_in = 1'b0;
    logic        irq, tc_pulse, shutdown_req, reset_req;

    int total = 0;
    int bad   = 0;
    logic [31:0] v;

    always #5 clk = ~clk;

    aux_ctrl_bank dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_sel      (reg_sel),
        .word_off     (word_off),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .pwr_fail_in  (pwr_fail_in),
        .irq          (irq),
        .tc_pulse     (tc_pulse),
        .shutdown_req (shutdown_req),
        .reset_req    (reset_req)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    // ends on the negedge after the write edge
    task automatic wr(input int idx, input logic [1:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_sel  = 7'(1) << idx;
        word_off = off;
        wr_data  = d;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en    = 1'b0;
        reg_sel  = '0;
        word_off = '0;
    endtask

    task automatic rd(input int idx, input logic [1:0] off, output logic [31:0] r);
        reg_sel  = 7'(1) << idx;
        word_off = off;
        #1 r = rd_data;
        reg_sel  = '0;
        word_off = '0;
    endtask

    task automatic pulses(input string tag, input logic [2:0] exp);
        check(tag, {29'd0, reset_req, shutdown_req, tc_pulse}, {29'd0, exp});
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: got=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: R8 R10 R11
        rd(CFG, 0, v);  check("R8 cfg after reset", v, 0);
        rd(AUX1, 0, v); check("R8 aux1 after reset", v, 0);
        rd(AUX2, 0, v); check("R8 aux2 after reset", v, 0);
        rd(MDM, 0, v);  check("R8 modem after reset", v, 0);
        pulses("R10 pulses low after reset", 3'b000);
        check("R1 irq low after reset", {31'd0, irq}, 0);
        #1 check("R11 no select reads zero", rd_data, 0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].idx, VECS[i].off, VECS[i].wd);
            rd(VECS[i].idx, VECS[i].off, v);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
        end
        rd(LED, 0, v);  check("R9 led kept after offset write", v, 32'h0000_BEEF);
        rd(SYSC, 0, v); check("R9 sysc kept after offset write", v, 32'h2);

        // terminal count pulse R3 R10
        wr(AUX1, 0, 32'h02);
        pulses("R3 tc pulse after write", 3'b001);
        rd(AUX1, 0, v); check("R3 aux1 bit1 stored zero", v, 0);
        @(negedge clk);
        pulses("R10 tc pulse one cycle", 3'b000);

        // shutdown R5
        wr(AUX2, 0, 32'h01);
        pulses("R5 shutdown pulse", 3'b010);
        rd(AUX2, 0, v); check("R5 aux2 power-off stored", v, 32'h01);
        @(negedge clk);
        pulses("R10 shutdown one cycle", 3'b000);
        wr(AUX2, 0, 32'h00);
        pulses("R5 no shutdown on bit0 clear", 3'b000);

        // reset request R6 R9
        wr(SYSC, 0, 32'h3);
        pulses("R6 reset request pulse", 3'b100);
        @(negedge clk);
        pulses("R10 reset request one cycle", 3'b000);
        wr(SYSC, 1, 32'h1);
        pulses("R9 no request at offset 1", 3'b000);

        // power fail sequence R1 R2 R4
        wr(CFG, 0, 32'h08);
        check("R1 irq low with no fail", {31'd0, irq}, 0);
        pwr_fail_in = 1'b1;
        @(negedge clk);
        check("R2 irq after fail edge", {31'd0, irq}, 1);
        rd(AUX2, 0, v); check("R2 flag set in aux2", v, 32'h20);
        wr(CFG, 0, 32'h00);
        check("R1 irq masked by cfg", {31'd0, irq}, 0);
        rd(AUX2, 0, v); check("R1 flag kept while masked", v, 32'h20);
        wr(CFG, 0, 32'h08);
        check("R1 irq returns on enable", {31'd0, irq}, 1);
        wr(AUX2, 0, 32'hFC);
        rd(AUX2, 0, v); check("R4 flag kept, data masked", v, 32'h20);
        check("R4 irq kept", {31'd0, irq}, 1);
        wr(AUX2, 0, 32'h23);
        rd(AUX2, 0, v); check("R4 clear leaves bit0 only", v, 32'h01);
        check("R4 irq cleared", {31'd0, irq}, 0);
        pulses("R5 shutdown with clear", 3'b010);
        pwr_fail_in = 1'b0;
        @(negedge clk);
        wr(CFG, 0, 32'h00);
        pwr_fail_in = 1'b1;
        @(negedge clk);
        rd(AUX2, 0, v); check("R2 no flag when disabled", v, 32'h01);
        wr(CFG, 0, 32'h08);
        check("R2 enable alone sets nothing", {31'd0, irq}, 0);
        pwr_fail_in = 1'b0;
        @(negedge clk);
        pwr_fail_in = 1'b1;
        @(negedge clk);
        check("R2 flag on new edge", {31'd0, irq}, 1);
        pwr_fail_in = 1'b0;
        @(negedge clk);
        check("R2 falling input clears flag", {31'd0, irq}, 0);
        rd(AUX2, 0, v); check("R2 flag bit cleared", v, 32'h01);

        // reset preserve R8
        wr(DIAG, 0, 32'h77);
        wr(LED, 0, 32'h55AA);
        wr(MDM, 0, 32'h33);
        pwr_fail_in = 1'b1;
        @(negedge clk);
        check("R8 irq set before reset", {31'd0, irq}, 1);
        pwr_fail_in = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(CFG, 0, v);  check("R8 cfg cleared", v, 0);
        rd(MDM, 0, v);  check("R8 modem cleared", v, 0);
        rd(AUX2, 0, v); check("R8 aux2 and flag cleared", v, 0);
        rd(DIAG, 0, v); check("R8 diag kept", v, 32'h77);
        rd(LED, 0, v);  check("R8 led kept", v, 32'h55AA);
        rd(SYSC, 0, v); check("R8 sysc kept", v, 32'h2);
        check("R8 irq cleared", {31'd0, irq}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule